// File: doc/BRIEF.md
# Module Status LED Controller

This block turns four module status inputs into the two enable lines of a red/green indicator LED. A steady green shows that the module has finished initialisation. Each access event is stretched into a visible amber flash, made by lighting red and green together. An over-temperature condition blinks the LED red, and a hardware error holds it solid red. When several conditions are present at once, a fixed priority picks the one that is shown.

Timing is derived from the system clock. The amber flash lasts 50 ms, computed from a clock-frequency parameter. The red blink runs at a parameterised rate, by default 2 Hz with equal on and off halves. An access that arrives while a flash is still showing starts the full interval again. The flash timer keeps running while a higher-priority state hides it.

Top module: `status_led_top`

## Requirements
- R1: While rst_n is low, and in the cycle after its release with no condition present, ledRed and ledGreen are both 0.
- R2: With only initDone high, ledGreen=1 and ledRed=0 from the cycle after initDone is first sampled high.
- R3: An accessPulse sampled high at a clock edge gives amber (ledRed=1, ledGreen=1) for exactly FLASH_CYCLES cycles, starting one cycle later. FLASH_CYCLES = CLK_HZ/1000*FLASH_MS, and FLASH_MS defaults to 50.
- R4: An accessPulse during an active flash restarts the interval, so amber lasts FLASH_CYCLES cycles from the latest pulse.
- R5: While overTemp is high, ledGreen=0 and ledRed alternates. It is 1 for BLINK_HALF cycles, then 0 for BLINK_HALF cycles, starting with the on half in the cycle after overTemp is first sampled high. BLINK_HALF = CLK_HZ/(2*BLINK_HZ).
- R6: While hwError is high, ledRed=1 and ledGreen=0 from the next cycle.
- R7: Priority from highest to lowest is hwError, then overTemp, then an active flash, then initDone, then off.
- R8: The flash interval keeps counting while hwError or overTemp hides it. When they clear, amber shows only for whatever remains of FLASH_CYCLES.
- R9: If overTemp falls and later rises again, the blink restarts with its on half.
- R10: With no input high, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| initDone | input | 1 | Module has been initialised |
| accessPulse | input | 1 | One or more cycles of module access |
| overTemp | input | 1 | Over-temperature condition present |
| hwError | input | 1 | Hardware error detected |
| ledRed | output | 1 | Red LED enable |
| ledGreen | output | 1 | Green LED enable |

## Verification
The bench keeps its own model, which counts the cycles since the last access and since overTemp rose, and compares both outputs with it in every cycle.

- A single access pulse measures the exact flash length.
- A sweep of the gap between two pulses, across the whole interval and just past it, separates a restart from an extension or an ignored retrigger.
- Holding overTemp for several blink periods, then re-raising it, checks the half-period length and the phase restart.
- Walking all sixteen input combinations, and hiding a flash under hwError and overTemp, exposes any priority swap or a timer that freezes while it is masked.
- A long pseudo-random input stream mixes all of these.

// File: rtl/led_pkg.sv
package led_pkg;

  // Strobes from the control into the timing datapath
  typedef struct packed {
    logic flashLoad;   // restart the amber stretch interval
    logic blinkRun;    // let the blink counter advance
  } ledStrobe_t;

  // Colour shown on the LED, one value per visible pattern
  typedef enum logic [2:0] {
    SHOW_OFF      = 3'd0,
    SHOW_GREEN    = 3'd1,
    SHOW_AMBER    = 3'd2,
    SHOW_BLINK_ON = 3'd3,
    SHOW_BLINK_DK = 3'd4,
    SHOW_RED      = 3'd5
  } ledShow_t;

endpackage

// File: rtl/led_timers.sv
module led_timers
  import led_pkg::*;
#(
  parameter int FLASH_CYCLES = 5000000,
  parameter int BLINK_HALF   = 25000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ledStrobe_t strobe,
  output logic       flashActive,
  output logic       blinkPhase
);

  localparam int FW = $clog2(FLASH_CYCLES + 1);
  localparam int BW = $clog2(BLINK_HALF + 1);
  localparam logic [FW-1:0] FLASH_LOAD = FW'(FLASH_CYCLES - 1);
  localparam logic [BW-1:0] BLINK_LAST = BW'(BLINK_HALF - 1);

  logic [FW-1:0] flashCnt;
  logic [BW-1:0] blinkCnt;

  // Amber stretch: the cycle of the strobe itself counts as the first
  // cycle, so the counter holds the number of cycles still to come.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flashCnt <= '0;
    end else if (strobe.flashLoad) begin
      flashCnt <= FLASH_LOAD;
    end else if (flashCnt != '0) begin
      flashCnt <= flashCnt - 1'b1;
    end
  end

  assign flashActive = (flashCnt != '0);

  // Blink half-period counter; idles in the lit phase so a new
  // over-temperature always starts with red on.
  always_ff @(posedge clk) begin
    if (!rst_n || !strobe.blinkRun) begin
      blinkCnt   <= '0;
      blinkPhase <= 1'b1;
    end else if (blinkCnt == BLINK_LAST) begin
      blinkCnt   <= '0;
      blinkPhase <= ~blinkPhase;
    end else begin
      blinkCnt   <= blinkCnt + 1'b1;
    end
  end

  // R3 / R4: a load always restarts the full interval
  a_r4_flash_restart: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flashLoad |=> flashCnt == FLASH_LOAD);

  // R3: the interval shrinks by exactly one per cycle without a load
  a_r3_flash_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.flashLoad && flashCnt != '0) |=> flashCnt == $past(flashCnt) - 1'b1);

  // R5: the half-period counter stays inside its window
  a_r5_blink_bound: assert property (@(posedge clk) disable iff (!rst_n)
    blinkCnt <= BLINK_LAST);

  // R9: stopping the blink parks it at the start of the lit half
  a_r9_blink_park: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.blinkRun |=> (blinkPhase && blinkCnt == '0));

endmodule

// File: rtl/led_ctrl.sv
module led_ctrl
  import led_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       initDone,
  input  logic       accessPulse,
  input  logic       overTemp,
  input  logic       hwError,
  input  logic       flashActive,
  input  logic       blinkPhase,
  output ledStrobe_t strobe,
  output logic       ledRed,
  output logic       ledGreen
);

  ledShow_t showQ, showD;
  logic     flashNow;

  always_comb begin
    strobe.flashLoad = accessPulse;
    strobe.blinkRun  = overTemp;
  end

  // A pulse this cycle counts as an active flash immediately
  assign flashNow = accessPulse | flashActive;

  // Fixed priority selection of the colour to show
  always_comb begin
    if (hwError)       showD = SHOW_RED;
    else if (overTemp) showD = blinkPhase ? SHOW_BLINK_ON : SHOW_BLINK_DK;
    else if (flashNow) showD = SHOW_AMBER;
    else if (initDone) showD = SHOW_GREEN;
    else               showD = SHOW_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) showQ <= SHOW_OFF;
    else        showQ <= showD;
  end

  always_comb begin
    ledRed   = 1'b0;
    ledGreen = 1'b0;
    unique case (showQ)
      SHOW_GREEN:    ledGreen = 1'b1;
      SHOW_AMBER:    begin ledRed = 1'b1; ledGreen = 1'b1; end
      SHOW_BLINK_ON: ledRed = 1'b1;
      SHOW_RED:      ledRed = 1'b1;
      default:       ;
    endcase
  end

  a_r6_error_red: assert property (@(posedge clk) disable iff (!rst_n)
    hwError |=> (ledRed && !ledGreen));

  a_r7_amber_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    (accessPulse && !hwError && !overTemp) |=> (ledRed && ledGreen));

  a_r2_green_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (initDone && !flashNow && !overTemp && !hwError) |=> (ledGreen && !ledRed));

  a_r9_blink_starts_lit: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(overTemp) && !hwError) |=> (ledRed && !ledGreen));

  a_r10_dark_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!initDone && !flashNow && !overTemp && !hwError) |=> (!ledRed && !ledGreen));

endmodule

// File: rtl/status_led_top.sv
module status_led_top
  import led_pkg::*;
#(
  parameter int CLK_HZ   = 100000000,
  parameter int FLASH_MS = 50,
  parameter int BLINK_HZ = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic initDone,
  input  logic accessPulse,
  input  logic overTemp,
  input  logic hwError,
  output logic ledRed,
  output logic ledGreen
);

  localparam int FLASH_CYCLES = (CLK_HZ / 1000) * FLASH_MS;
  localparam int BLINK_HALF   = CLK_HZ / (2 * BLINK_HZ);

  ledStrobe_t strobe;
  logic       flashActive;
  logic       blinkPhase;

  led_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .initDone    (initDone),
    .accessPulse (accessPulse),
    .overTemp    (overTemp),
    .hwError     (hwError),
    .flashActive (flashActive),
    .blinkPhase  (blinkPhase),
    .strobe      (strobe),
    .ledRed      (ledRed),
    .ledGreen    (ledGreen)
  );

  led_timers #(
    .FLASH_CYCLES (FLASH_CYCLES),
    .BLINK_HALF   (BLINK_HALF)
  ) i_timers (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .flashActive (flashActive),
    .blinkPhase  (blinkPhase)
  );

  // R1: reset leaves the LED dark
  a_r1_reset_dark: assert property (@(posedge clk)
    !rst_n |=> (!ledRed && !ledGreen));

endmodule

// File: tb/test_status_led_top.sv
module test_status_led_top;

  localparam int CLK_HZ = 1000;
  localparam int FL_MS  = 20;
  localparam int BL_HZ  = 50;
  localparam int FL     = CLK_HZ / 1000 * FL_MS;   // 20 cycles
  localparam int HALF   = CLK_HZ / (2 * BL_HZ);    // 10 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic initDone = 1'b0, accessPulse = 1'b0, overTemp = 1'b0, hwError = 1'b0;
  logic ledRed, ledGreen;

  int total = 0;
  int bad = 0;
  bit checkOn = 1'b0;
  bit finished = 1'b0;
  string curTag = "R1";

  always #2 clk = ~clk;   // 250 MHz

  status_led_top #(.CLK_HZ(CLK_HZ), .FLASH_MS(FL_MS), .BLINK_HZ(BL_HZ)) i_status_led_top (
    .clk(clk), .rst_n(rst_n), .initDone(initDone), .accessPulse(accessPulse),
    .overTemp(overTemp), .hwError(hwError), .ledRed(ledRed), .ledGreen(ledGreen)
  );

  // Behavioural expectation: ages since last access and since overTemp rose
  int fAge = FL;
  int otAge = 0;
  logic expR = 1'b0, expG = 1'b0;

  always @(posedge clk) begin
    int nf;
    int no;
    if (!rst_n) begin
      fAge <= FL; otAge <= 0; expR <= 1'b0; expG <= 1'b0;
    end else begin
      nf = accessPulse ? 0 : ((fAge < FL) ? fAge + 1 : fAge);
      no = overTemp ? ((otAge > 0) ? otAge + 1 : 1) : 0;   // 1 = first cycle
      fAge <= nf; otAge <= no;
      if (hwError)          begin expR <= 1'b1; expG <= 1'b0; end
      else if (overTemp)    begin expR <= (((no - 1) / HALF) % 2 == 0); expG <= 1'b0; end
      else if (nf < FL)     begin expR <= 1'b1; expG <= 1'b1; end
      else if (initDone)    begin expR <= 1'b0; expG <= 1'b1; end
      else                  begin expR <= 1'b0; expG <= 1'b0; end
    end
  end

  always @(negedge clk) begin
    if (checkOn && !finished) begin
      total++;
      if (ledRed !== expR || ledGreen !== expG) begin
        bad++;
        $display("FAIL %s red/green act=%b%b exp=%b%b at %0t", curTag, ledRed, ledGreen, expR, expG, $time);
      end
    end
  end

  task automatic drive(input logic i, input logic a, input logic o, input logic h, input int n);
    @(negedge clk);
    initDone = i; accessPulse = a; overTemp = o; hwError = h;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lfsr;
    curTag = "R1";
    repeat (2) @(negedge clk);
    checkOn = 1'b1;                       // R1: outputs dark while in reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    curTag = "R10"; drive(0, 0, 0, 0, 10);
    curTag = "R2";  drive(1, 0, 0, 0, 20);
    curTag = "R3";  drive(1, 1, 0, 0, 1); drive(1, 0, 0, 0, FL + 5);
    curTag = "R3";  drive(0, 1, 0, 0, 1); drive(0, 0, 0, 0, FL + 5);
    curTag = "R4";
    for (int gap = 1; gap <= FL + 2; gap++) begin
      drive(1, 1, 0, 0, 1); drive(1, 0, 0, 0, gap);
      drive(1, 1, 0, 0, 1); drive(1, 0, 0, 0, FL + 3);
    end
    curTag = "R4";  drive(1, 1, 0, 0, 3 * FL); drive(1, 0, 0, 0, FL + 3);
    curTag = "R5";  drive(1, 0, 1, 0, 6 * HALF + 3);
    curTag = "R9";  drive(1, 0, 0, 0, 4); drive(1, 0, 1, 0, 3 * HALF);
    drive(1, 0, 0, 0, HALF / 2); drive(1, 0, 1, 0, 2 * HALF + 1);
    curTag = "R6";  drive(1, 0, 0, 1, 15); drive(0, 0, 0, 1, 5);
    curTag = "R7";
    for (int c = 0; c < 16; c++) begin
      drive(c[0], c[1], c[2], c[3], 2 * HALF + 1);
      drive(0, 0, 0, 0, FL + 1);
    end
    curTag = "R8";
    drive(1, 1, 0, 0, 1); drive(1, 0, 0, 1, 6); drive(1, 0, 0, 0, FL);
    drive(1, 1, 0, 0, 1); drive(1, 0, 1, 0, 8); drive(1, 0, 0, 0, FL);
    drive(1, 1, 0, 0, 1); drive(1, 0, 1, 1, FL + 2); drive(1, 0, 0, 0, 5);
    curTag = "R7";
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3] & lfsr[4],
            lfsr[5] & lfsr[6] & lfsr[7], lfsr[8] & lfsr[9] & lfsr[11] & lfsr[12], 1);
    end
    curTag = "R1";
    drive(1, 1, 1, 1, 2);
    rst_n = 1'b0; drive(0, 0, 0, 0, 4);
    rst_n = 1'b1; curTag = "R10"; drive(0, 0, 0, 0, 5);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog %s act=timeout exp=done", curTag);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule